// File: doc/BRIEF.md
# Multiply, Divide and Accumulate Coprocessor

A small arithmetic engine reached through a register read/write port. Software loads a 16-bit operand into the A register, picks one of four operations in the control register, and then writes the B register. That last write launches the operation. When the work is done, the 32-bit answer appears in two 16-bit result registers. A busy output, which is also readable in the status register, stays high while the result is not yet valid.

Four operations are supported: unsigned multiply, signed multiply, signed multiply-accumulate into a 32-bit accumulator, and unsigned divide.

- A multiply takes one cycle.
- A multiply-accumulate takes two cycles. The first cycle registers the product and the second adds it into the accumulator.
- A divide takes sixteen cycles. It uses a restoring shift-subtract loop that resolves one quotient bit per cycle. The quotient lands in the low half of the result and the remainder in the high half.

Two sticky flags can be read back: one for division by zero and one for signed overflow of the accumulator. Writing the clear bit in the control register resets both flags and the accumulator.

Top module: `muldiv_mac`

## Requirements
- R1: After reset, every readable register (addresses 0 to 7) reads zero and busy_o is low.
- R2: The register map is: 0 operand A, 1 operand B, 2 control (mode in bits 1:0, clear action in bit 4, reads back the mode), 3 result low half, 4 result high half, 5 status (bit 0 busy, bit 1 divide-by-zero, bit 2 overflow), 6 accumulator low half, 7 accumulator high half. A write to address 1 while idle starts the selected operation, and busy_o is high from the next cycle.
- R3: Mode 0 (unsigned multiply) keeps busy_o high for exactly one cycle and leaves the 32-bit unsigned product of A and B in the result registers.
- R4: Mode 1 (signed multiply) keeps busy_o high for exactly one cycle and leaves the two's-complement product of A and B in the result registers.
- R5: Mode 2 (multiply-accumulate) keeps busy_o high for exactly two cycles, adds the signed product of A and B to the accumulator, and copies the new accumulator value into the result registers.
- R6: The accumulator wraps modulo 2^32. A signed overflow on an accumulate sets the overflow status bit, which stays set until a clear.
- R7: Mode 3 (unsigned divide) keeps busy_o high for exactly sixteen cycles. It leaves A/B in the result low half and A mod B in the result high half.
- R8: A divide by zero takes the same sixteen cycles. It returns 0xFFFF as the quotient and A as the remainder, and it sets the sticky divide-by-zero status bit.
- R9: Writing control with bit 4 set zeroes the accumulator, the overflow bit and the divide-by-zero bit.
- R10: While busy_o is high, writes to addresses 0, 1 and 2 are ignored. This covers operands, mode and the clear action, and the running operation completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| busy_o | output | 1 | High while an operation is in progress |

## Verification
The hardest situation to reach from the ports is a register write that arrives while a sixteen-cycle divide is still running. It must leave the operands, the mode and the accumulator untouched, and the divide must still finish with its original inputs. The stimulus starts a divide and then, within the busy window, issues writes to A, B and control, including a clear. It does this after an earlier multiply-accumulate has left a nonzero accumulator. Once busy drops, the operand, control and accumulator registers and the quotient/remainder are read back. The accumulator overflow is reached by repeatedly adding the largest positive signed product, so that the sum crosses 2^31.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_MAC  = 2'd2,
    MODE_DIV  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_MAC1,
    ST_MAC2,
    ST_DIV
  } state_e;

  localparam logic [2:0] ADR_OPA   = 3'd0;
  localparam logic [2:0] ADR_OPB   = 3'd1;
  localparam logic [2:0] ADR_CTRL  = 3'd2;
  localparam logic [2:0] ADR_RES_L = 3'd3;
  localparam logic [2:0] ADR_RES_H = 3'd4;
  localparam logic [2:0] ADR_STAT  = 3'd5;
  localparam logic [2:0] ADR_ACC_L = 3'd6;
  localparam logic [2:0] ADR_ACC_H = 3'd7;

  localparam int CLR_BIT = 4;

endpackage

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            signed_i,
  output logic [2*DW-1:0] prod_o
);

  logic signed [DW:0]     a_x, b_x;
  logic signed [2*DW-1:0] a_w, b_w;

  assign a_x = {signed_i & a_i[DW-1], a_i};
  assign b_x = {signed_i & b_i[DW-1], b_i};
  // low 2*DW bits are exact for both signednesses
  assign a_w = {{(DW-1){a_x[DW]}}, a_x};
  assign b_w = {{(DW-1){b_x[DW]}}, b_x};
  assign prod_o = a_w * b_w;

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          last_o,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);

  localparam int CW = $clog2(DW);

  logic [DW-1:0] quo_q, rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [DW:0]   shifted, diff;
  logic          neg;

  assign shifted = {rem_q, quo_q[DW-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign neg     = diff[DW];
  // restore on negative trial; zero divisor naturally yields all-ones / dividend
  assign rem_o   = neg ? shifted[DW-1:0] : diff[DW-1:0];
  assign quo_o   = {quo_q[DW-2:0], ~neg};
  assign last_o  = run_q && (cnt_q == CW'(DW-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      quo_q <= dividend_i;
      rem_q <= '0;
      dvs_q <= divisor_i;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      quo_q <= quo_o;
      rem_q <= rem_o;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/muldiv_acc.sv
module muldiv_acc #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         add_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);

  logic [W-1:0] acc_q;
  logic         ovf_q, ovf_now;

  assign sum_o   = acc_q + addend_i;
  assign ovf_now = (acc_q[W-1] == addend_i[W-1]) && (sum_o[W-1] != acc_q[W-1]);
  assign acc_o   = acc_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (add_i) begin
      acc_q <= sum_o;
      if (ovf_now) ovf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/muldiv_mac.sv
module muldiv_mac
  import muldiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o
);

  localparam int RW = 2 * DW;

  logic [DW-1:0] op_a_q, op_b_q;
  mode_e         mode_q;
  state_e        state_q;
  logic [RW-1:0] res_q, prod_q, prod, acc, acc_sum;
  logic          dz_q, ovf;
  logic          wr_a, wr_b, wr_c, start_w, clr_w;
  logic          div_last;
  logic [DW-1:0] div_quo, div_rem;

  assign busy_o  = (state_q != ST_IDLE);
  assign wr_a    = wr_en_i && !busy_o && (addr_i == ADR_OPA);
  assign wr_b    = wr_en_i && !busy_o && (addr_i == ADR_OPB);
  assign wr_c    = wr_en_i && !busy_o && (addr_i == ADR_CTRL);
  assign start_w = wr_b;
  assign clr_w   = wr_c && wdata_i[CLR_BIT];

  muldiv_mult #(.DW(DW)) u_mult (
    .a_i      (op_a_q),
    .b_i      (op_b_q),
    .signed_i (mode_q != MODE_UMUL),
    .prod_o   (prod)
  );

  muldiv_div #(.DW(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w && (mode_q == MODE_DIV)),
    .dividend_i (op_a_q),
    .divisor_i  (wdata_i),
    .last_o     (div_last),
    .quo_o      (div_quo),
    .rem_o      (div_rem)
  );

  muldiv_acc #(.W(RW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_w),
    .add_i    (state_q == ST_MAC2),
    .addend_i (prod_q),
    .acc_o    (acc),
    .sum_o    (acc_sum),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q  <= '0;
      op_b_q  <= '0;
      mode_q  <= MODE_UMUL;
      state_q <= ST_IDLE;
      res_q   <= '0;
      prod_q  <= '0;
      dz_q    <= 1'b0;
    end else begin
      if (wr_a) op_a_q <= wdata_i;
      if (wr_b) op_b_q <= wdata_i;
      if (wr_c) mode_q <= mode_e'(wdata_i[1:0]);
      if (clr_w) dz_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_w) begin
          unique case (mode_q)
            MODE_UMUL, MODE_SMUL: state_q <= ST_MUL;
            MODE_MAC:             state_q <= ST_MAC1;
            default: begin
              state_q <= ST_DIV;
              if (wdata_i == '0) dz_q <= 1'b1;
            end
          endcase
        end
        ST_MUL: begin
          res_q   <= prod;
          state_q <= ST_IDLE;
        end
        ST_MAC1: begin
          prod_q  <= prod;
          state_q <= ST_MAC2;
        end
        ST_MAC2: begin
          res_q   <= acc_sum;
          state_q <= ST_IDLE;
        end
        ST_DIV: if (div_last) begin
          res_q   <= {div_rem, div_quo};
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      ADR_OPA:   rdata_o = op_a_q;
      ADR_OPB:   rdata_o = op_b_q;
      ADR_CTRL:  rdata_o = {{(DW-2){1'b0}}, mode_q};
      ADR_RES_L: rdata_o = res_q[DW-1:0];
      ADR_RES_H: rdata_o = res_q[RW-1:DW];
      ADR_STAT:  rdata_o = {{(DW-3){1'b0}}, ovf, dz_q, busy_o};
      ADR_ACC_L: rdata_o = acc[DW-1:0];
      default:   rdata_o = acc[RW-1:DW];
    endcase
  end

endmodule

// File: rtl/muldiv_mac_chk.sv
module muldiv_mac_chk
  import muldiv_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          start_w,
  input logic          clr_w,
  input logic          wr_en_i,
  input logic [2:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input mode_e         mode_q,
  input logic [DW-1:0] op_a_q,
  input logic          dz_q,
  input logic          ovf,
  input logic [2*DW-1:0] acc
);

  localparam int LW = $clog2(DW) + 2;

  logic [LW-1:0] run_len, exp_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
      exp_len <= '0;
    end else if (start_w) begin
      run_len <= '0;
      unique case (mode_q)
        MODE_MAC: exp_len <= LW'(2);
        MODE_DIV: exp_len <= LW'(DW);
        default:  exp_len <= LW'(1);
      endcase
    end else if (busy_o) begin
      run_len <= run_len + 1'b1;
    end
  end

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> busy_o);

  // covers R3, R4 and R5 latencies too
  a_r7_op_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len == exp_len));

  a_r8_div_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && mode_q == MODE_DIV && wdata_i == '0) |=> dz_q);

  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf) |-> $past(clr_w));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> (acc == '0 && !ovf && !dz_q));

  a_r10_opa_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && addr_i == ADR_OPA) |=> $stable(op_a_q));

endmodule

bind muldiv_mac muldiv_mac_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .start_w (start_w),
  .clr_w   (clr_w),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .mode_q  (mode_q),
  .op_a_q  (op_a_q),
  .dz_q    (dz_q),
  .ovf     (ovf),
  .acc     (acc)
);

// File: tb/muldiv_mac_test.sv
`timescale 1ns/1ps
module muldiv_mac_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] acc_ref = 32'd0;
  logic        ovf_ref = 1'b0;

  always #2 clk_i = ~clk_i;

  muldiv_mac uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .busy_o  (busy_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy_o && cyc < 100) begin
      cyc++;
      @(negedge clk_i);
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] mode, input logic [15:0] a,
                        input logic [15:0] b, input int exp_lat, input logic [31:0] exp_res);
    int cyc;
    logic [15:0] lo, hi;
    wr(3'd2, {14'd0, mode});
    wr(3'd0, a);
    wr(3'd1, b);
    check({req, " busy after start"}, {31'd0, busy_o}, 32'd1);
    wait_idle(cyc);
    check({req, " latency"}, cyc, exp_lat);
    rd(3'd3, lo);
    rd(3'd4, hi);
    check({req, " result"}, {hi, lo}, exp_res);
  endtask

  function automatic logic [31:0] smul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] x, y;
    x = {{16{a[15]}}, a};
    y = {{16{b[15]}}, b};
    return x * y;
  endfunction

  task automatic mac_ref(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p, s;
    p = smul(a, b);
    s = acc_ref + p;
    if (acc_ref[31] == p[31] && s[31] != acc_ref[31]) ovf_ref = 1'b1;
    acc_ref = s;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 busy at reset", {31'd0, busy_o}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      check($sformatf("R1 reg %0d at reset", i), {16'd0, d}, 32'd0);
    end
  endtask

  task automatic t_umul;
    run_op("R3 umul max", 2'd0, 16'hFFFF, 16'hFFFF, 1, 32'hFFFE0001);
    run_op("R3 umul mid", 2'd0, 16'd1234, 16'd5678, 1, 32'd1234 * 32'd5678);
    run_op("R3 umul zero", 2'd0, 16'h0000, 16'hBEEF, 1, 32'd0);
  endtask

  task automatic t_smul;
    run_op("R4 smul neg neg", 2'd1, 16'hFFFF, 16'hFFFF, 1, 32'd1);
    run_op("R4 smul min max", 2'd1, 16'h8000, 16'h7FFF, 1, smul(16'h8000, 16'h7FFF));
    run_op("R4 smul neg pos", 2'd1, 16'hFFFD, 16'd5, 1, smul(16'hFFFD, 16'd5));
  endtask

  task automatic t_mac;
    logic [15:0] lo, hi;
    wr(3'd2, 16'h0010);
    acc_ref = 0; ovf_ref = 0;
    mac_ref(16'd3, 16'd4);
    run_op("R5 mac 1", 2'd2, 16'd3, 16'd4, 2, acc_ref);
    mac_ref(16'hFFF9, 16'd100);
    run_op("R5 mac 2", 2'd2, 16'hFFF9, 16'd100, 2, acc_ref);
    mac_ref(16'h7FFF, 16'h7FFF);
    run_op("R5 mac 3", 2'd2, 16'h7FFF, 16'h7FFF, 2, acc_ref);
    rd(3'd6, lo);
    rd(3'd7, hi);
    check("R5 acc readback", {hi, lo}, acc_ref);
  endtask

  task automatic t_ovf;
    logic [15:0] st;
    wr(3'd2, 16'h0010);
    acc_ref = 0; ovf_ref = 0;
    for (int i = 0; i < 3; i++) begin
      mac_ref(16'h8000, 16'h8000);
      run_op($sformatf("R6 wrap add %0d", i), 2'd2, 16'h8000, 16'h8000, 2, acc_ref);
      rd(3'd5, st);
      check($sformatf("R6 ovf flag after add %0d", i), {31'd0, st[2]}, {31'd0, ovf_ref});
    end
  endtask

  task automatic t_div;
    logic [15:0] st;
    run_op("R7 div 1000/7", 2'd3, 16'd1000, 16'd7, 16, {16'd6, 16'd142});
    run_op("R7 div max/1", 2'd3, 16'hFFFF, 16'd1, 16, {16'd0, 16'hFFFF});
    run_op("R7 div small/large", 2'd3, 16'd5, 16'd9, 16, {16'd5, 16'd0});
    run_op("R7 div 8000/100", 2'd3, 16'h8000, 16'h0100, 16, {16'd0, 16'h0080});
    rd(3'd5, st);
    check("R8 no dz flag on valid divides", {31'd0, st[1]}, 32'd0);
    run_op("R8 div by zero", 2'd3, 16'h1234, 16'd0, 16, {16'h1234, 16'hFFFF});
    rd(3'd5, st);
    check("R8 dz flag set", {31'd0, st[1]}, 32'd1);
    run_op("R8 dz sticky across valid div", 2'd3, 16'd9, 16'd3, 16, {16'd0, 16'd3});
    rd(3'd5, st);
    check("R8 dz flag still set", {31'd0, st[1]}, 32'd1);
  endtask

  task automatic t_clear;
    logic [15:0] st, lo, hi;
    wr(3'd2, 16'h0012);
    rd(3'd5, st);
    check("R9 flags after clear", {29'd0, st[2:0]}, 32'd0);
    rd(3'd6, lo);
    rd(3'd7, hi);
    check("R9 acc after clear", {hi, lo}, 32'd0);
    rd(3'd2, st);
    check("R2 ctrl readback mode", {16'd0, st}, 32'd2);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] d, lo, hi;
    int cyc;
    wr(3'd2, 16'h0010);
    acc_ref = 0; ovf_ref = 0;
    mac_ref(16'd21, 16'd2);
    run_op("R10 setup mac", 2'd2, 16'd21, 16'd2, 2, acc_ref);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'd1000);
    wr(3'd1, 16'd7);
    wr(3'd0, 16'd55);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'h0010);
    wait_idle(cyc);
    check("R10 latency unchanged", cyc + 6, 32'd16);
    rd(3'd3, lo);
    rd(3'd4, hi);
    check("R10 result uses original operands", {hi, lo}, {16'd6, 16'd142});
    rd(3'd0, d);
    check("R10 opA unchanged", {16'd0, d}, 32'd1000);
    rd(3'd1, d);
    check("R10 opB unchanged", {16'd0, d}, 32'd7);
    rd(3'd2, d);
    check("R10 mode unchanged", {16'd0, d}, 32'd3);
    rd(3'd6, lo);
    rd(3'd7, hi);
    check("R10 acc not cleared", {hi, lo}, acc_ref);
    rd(3'd5, d);
    check("R10 dz not set by ignored zero write", {31'd0, d[1]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_umul();
    t_smul();
    t_mac();
    t_ovf();
    t_clear();
    t_div();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule